// File: doc/BRIEF.md
# Adaptive-Rate Switch-Array Regulator Controller

This block is the digital control loop of a switched-array linear regulator. A bank of identical power switches sits between the supply rail and the load. Each switch is driven fully on or fully off. On every sampling event the controller reads one comparator bit that says whether the regulated output sits below or above its target. It then turns exactly one more switch on, or exactly one switch off. The set of enabled switches always forms a contiguous run from bit 0 upward, so the binary count of conducting switches fully describes the loop state.

Two further comparator inputs flag large excursions: one for a deep droop and one for a large overshoot. While either flag is present, the sampling enable is generated at a fast divide ratio, so the array tracks the load quickly. Once both flags have cleared, the fast rate stays in force for a fixed number of additional samples. The block then returns to the slow ratio, which saves switching energy and reduces ripple. A bypass input forces every switch on, which ties the load straight to the rail. Bypass freezes regulation, and the stored count is kept for the moment bypass is released. All three comparator inputs pass through two-flop synchronizers. The sampling rates come from one system clock.

Top module: `dldo_ctrl`

## Requirements
- R1: A synchronous active-low reset sets the switch count to INIT_COUNT, sets `sw_en_o` to the matching thermometer pattern, and selects the slow rate (`fast_mode_o` = 0). It also clears the synchronizers and the sample divider.
- R2: Bit i of `sw_en_o` is 1 exactly when i is less than the switch count, so the pattern is thermometer coded from bit 0. `sw_cnt_o` is that count in binary.
- R3: In slow mode a sampling event falls on every SLOW_DIV-th clock edge, counted from reset release or from the return to slow mode. At a sampling event the count rises by exactly one when the synchronized `cmp_below_i` is 1 and falls by exactly one when it is 0. Between sampling events the count does not change.
- R4: The count saturates. It stays at N_SW when asked to rise and at 0 when asked to fall, and it never wraps.
- R5: Each comparator input is used only after two synchronizer flops. A level applied before clock edge k first steers an update at edge k+2 at the earliest, and an update at edge k+1 still uses the previous level.
- R6: A 1 on `droop_flag_i` or on `over_flag_i` held before edge k sets fast mode at edge k+2. In fast mode a sampling event falls on every FAST_DIV-th edge after entry. If a slow sampling event coincides with entry, that event still applies.
- R7: After the last edge k at which either flag was applied as 1, fast mode ends at edge k+2+HOLD_SAMPLES (with FAST_DIV = 1), after HOLD_SAMPLES fast samples with both flags clear. The slow divider then restarts from zero.
- R8: While `bypass_i` is 1, every bit of `sw_en_o` is 1 and `sw_cnt_o` reads N_SW in the same cycle. Sampling events during bypass leave the stored count unchanged, and that count reappears on the outputs as soon as `bypass_i` returns to 0.
- R9: `fast_mode_o` is 1 exactly while the fast rate is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_below_i | input | 1 | Asynchronous comparator: 1 = output below target, 0 = above |
| droop_flag_i | input | 1 | Asynchronous comparator: deep droop detected |
| over_flag_i | input | 1 | Asynchronous comparator: large overshoot detected |
| bypass_i | input | 1 | 1 = all switches on, regulation frozen |
| sw_en_o | output | N_SW | Thermometer-coded switch gate enables, bit 0 first |
| sw_cnt_o | output | $clog2(N_SW+1) | Number of enabled switches, binary |
| fast_mode_o | output | 1 | 1 while the fast sampling rate is selected |

## Verification
A corrupted count shows at the ports in the same cycle. It appears both as a thermometer pattern that disagrees with `sw_cnt_o` and as a count that departs from the arithmetic expectation on the very next negative clock edge. A divider or mode register in the wrong state shifts the next update edge. That shift is seen within one slow period, because every cycle is compared against the expected set of update edges. A wrong hold counter moves the fall of `fast_mode_o` and changes how many one-step moves the count makes after a flag clears. A synchronizer that is too short or too long moves the first update after a comparator change by one edge, and the bench aims one case directly at that edge.

// File: rtl/dldo_pkg.sv
// Shared types for the adaptive-rate switch-array regulator controller.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package dldo_pkg;

    // Sampling-rate selection of the control loop.
    typedef enum logic {
        RATE_SLOW = 1'b0,
        RATE_FAST = 1'b1
    } rate_e;

    // Bundle of the three comparator levels after synchronization.
    typedef struct packed {
        logic below;
        logic droop;
        logic over;
    } cmp_bus_t;

    localparam int CMP_BUS_W = $bits(cmp_bus_t);

endpackage

// File: rtl/dldo_sync.sv
// Multi-stage flop synchronizer for a bus of independent single-bit levels.
// Assumes: each bit is a slowly changing level, so bits may be resolved
// on different cycles without harm. Reset clears every stage.
module dldo_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the sampled levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/dldo_rate_gen.sv
// Sample-enable generator with two divide ratios and a post-excursion hold.
// Slow mode: sample_o pulses once every SLOW_DIV clocks.
// Fast mode: entered on the first clock with excursion_i set; pulses every
// FAST_DIV clocks; left after HOLD_SAMPLES fast pulses with excursion_i low.
// Assumes: SLOW_DIV, FAST_DIV, HOLD_SAMPLES are all at least 1.
module dldo_rate_gen #(
    parameter int SLOW_DIV     = 16,
    parameter int FAST_DIV     = 1,
    parameter int HOLD_SAMPLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic excursion_i,
    output logic sample_o,
    output logic fast_o
);
    import dldo_pkg::*;

    localparam int DIV_MAX = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int DIV_W   = $clog2(DIV_MAX + 1);
    localparam int HOLD_W  = $clog2(HOLD_SAMPLES + 1);
    localparam logic [DIV_W-1:0]  SLOW_LAST = DIV_W'(SLOW_DIV - 1);
    localparam logic [DIV_W-1:0]  FAST_LAST = DIV_W'(FAST_DIV - 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_SAMPLES - 1);

    rate_e             rate_q;
    logic [DIV_W-1:0]  div_q;
    logic [HOLD_W-1:0] hold_q;
    logic [DIV_W-1:0]  div_last;

    // Terminal divider value for the rate currently in force.
    always_comb begin
        div_last = (rate_q == RATE_FAST) ? FAST_LAST : SLOW_LAST;
    end

    assign sample_o = (div_q == div_last);
    assign fast_o   = (rate_q == RATE_FAST);

    // Advance the divider and move between slow and fast rates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= RATE_SLOW;
            div_q  <= '0;
            hold_q <= '0;
        end else begin
            unique case (rate_q)
                RATE_SLOW: begin
                    if (excursion_i) begin
                        rate_q <= RATE_FAST;
                        div_q  <= '0;
                        hold_q <= '0;
                    end else if (sample_o) begin
                        div_q <= '0;
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                RATE_FAST: begin
                    if (excursion_i) begin
                        hold_q <= '0;
                        div_q  <= sample_o ? '0 : div_q + 1'b1;
                    end else if (sample_o) begin
                        div_q <= '0;
                        if (hold_q == HOLD_LAST) begin
                            rate_q <= RATE_SLOW;
                            hold_q <= '0;
                        end else begin
                            hold_q <= hold_q + 1'b1;
                        end
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                default: begin
                    rate_q <= RATE_SLOW;
                    div_q  <= '0;
                    hold_q <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/dldo_step_ctrl.sv
// Saturating up/down switch counter with thermometer-coded gate outputs.
// One step per sample; bypass forces every gate on and freezes the count.
// Assumes: INIT_COUNT lies in 0..N_SW.
module dldo_step_ctrl #(
    parameter int N_SW       = 32,
    parameter int INIT_COUNT = 16,
    parameter int CNT_W      = $clog2(N_SW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_i,
    input  logic             below_i,
    input  logic             bypass_i,
    output logic [N_SW-1:0]  sw_en_o,
    output logic [CNT_W-1:0] sw_cnt_o
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(N_SW);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(INIT_COUNT);

    logic [CNT_W-1:0] cnt_q;
    logic             step_en;
    logic             can_rise;
    logic             can_fall;

    assign step_en  = sample_i && !bypass_i;
    assign can_rise = (cnt_q != CNT_FULL);
    assign can_fall = (cnt_q != '0);

    // Move the stored count one step toward the comparator request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_INIT;
        end else if (step_en) begin
            if (below_i && can_rise) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (!below_i && can_fall) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // One gate per switch: on below the count, or on for bypass.
    for (genvar g = 0; g < N_SW; g++) begin : g_gate
        assign sw_en_o[g] = bypass_i || (cnt_q > CNT_W'(g));
    end

    assign sw_cnt_o = bypass_i ? CNT_FULL : cnt_q;

endmodule

// File: rtl/dldo_ctrl.sv
// Top of the adaptive-rate switch-array regulator controller.
// Synchronizes the three comparator levels, derives the sample enable
// from the excursion flags and steps the thermometer switch array.
// Assumes: comparator inputs are asynchronous levels; bypass_i is
// synchronous to clk.
module dldo_ctrl #(
    parameter int N_SW         = 32,
    parameter int INIT_COUNT   = 16,
    parameter int SLOW_DIV     = 16,
    parameter int FAST_DIV     = 1,
    parameter int HOLD_SAMPLES = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmp_below_i,
    input  logic                       droop_flag_i,
    input  logic                       over_flag_i,
    input  logic                       bypass_i,
    output logic [N_SW-1:0]            sw_en_o,
    output logic [$clog2(N_SW+1)-1:0]  sw_cnt_o,
    output logic                       fast_mode_o
);
    import dldo_pkg::*;

    localparam int CNT_W = $clog2(N_SW + 1);

    cmp_bus_t cmp_raw;
    cmp_bus_t cmp_sync;
    logic     sample;
    logic     excursion;

    assign cmp_raw.below = cmp_below_i;
    assign cmp_raw.droop = droop_flag_i;
    assign cmp_raw.over  = over_flag_i;

    dldo_sync #(
        .WIDTH  (CMP_BUS_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_raw),
        .sync_o  (cmp_sync)
    );

    assign excursion = cmp_sync.droop || cmp_sync.over;

    dldo_rate_gen #(
        .SLOW_DIV     (SLOW_DIV),
        .FAST_DIV     (FAST_DIV),
        .HOLD_SAMPLES (HOLD_SAMPLES)
    ) u_rate (
        .clk         (clk),
        .rst_n       (rst_n),
        .excursion_i (excursion),
        .sample_o    (sample),
        .fast_o      (fast_mode_o)
    );

    dldo_step_ctrl #(
        .N_SW       (N_SW),
        .INIT_COUNT (INIT_COUNT),
        .CNT_W      (CNT_W)
    ) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample),
        .below_i  (cmp_sync.below),
        .bypass_i (bypass_i),
        .sw_en_o  (sw_en_o),
        .sw_cnt_o (sw_cnt_o)
    );

endmodule

// File: rtl/dldo_ctrl_chk.sv
// Port-level property checker for dldo_ctrl, attached by bind.
// Assumes: FAST_DIV = 1 timing for the exit check window is not needed;
// both mode checks only relate mode edges to flag levels three cycles back.
module dldo_ctrl_chk #(
    parameter int N_SW  = 32,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             droop_flag_i,
    input logic             over_flag_i,
    input logic             bypass_i,
    input logic [N_SW-1:0]  sw_en_o,
    input logic [CNT_W-1:0] sw_cnt_o,
    input logic             fast_mode_o
);

    logic [1:0]      seen_q;
    logic [N_SW-1:0] en_plus_one;

    assign en_plus_one = sw_en_o + {{(N_SW-1){1'b0}}, 1'b1};

    // Count edges since reset release, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 2'd0;
        end else if (seen_q != 2'd3) begin
            seen_q <= seen_q + 2'd1;
        end
    end

    // R2
    therm_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en_o & en_plus_one) == '0);

    // R2
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sw_en_o) == int'(sw_cnt_o));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sw_cnt_o) <= N_SW);

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd3 && !bypass_i && !$past(bypass_i)) |->
        (int'(sw_cnt_o) <= int'($past(sw_cnt_o)) + 1 &&
         int'(sw_cnt_o) + 1 >= int'($past(sw_cnt_o))));

    // R8
    bypass_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_i |-> (&sw_en_o));

    // R6
    fast_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd3 && $rose(fast_mode_o)) |->
        $past(droop_flag_i || over_flag_i, 3));

    // R7
    fast_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd3 && $fell(fast_mode_o)) |->
        $past(!(droop_flag_i || over_flag_i), 3));

endmodule

bind dldo_ctrl dldo_ctrl_chk #(
    .N_SW  (N_SW),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .droop_flag_i (droop_flag_i),
    .over_flag_i  (over_flag_i),
    .bypass_i     (bypass_i),
    .sw_en_o      (sw_en_o),
    .sw_cnt_o     (sw_cnt_o),
    .fast_mode_o  (fast_mode_o)
);

// File: tb/dldo_ctrl_test.sv
`timescale 1ns/1ps
// Self-checking bench: small configuration (8 switches, slow /4, fast /1,
// hold 3), every cycle compared against edges derived from the requirements.
module dldo_ctrl_test;

    localparam int NSW   = 8;
    localparam int INIT  = 4;
    localparam int SDIV  = 4;
    localparam int HOLD  = 3;
    localparam int CW    = $clog2(NSW + 1);
    localparam int LAST  = 150;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          below = 1'b1;
    logic          droop = 1'b0;
    logic          over = 1'b0;
    logic          bypass = 1'b0;
    logic [NSW-1:0] sw_en;
    logic [CW-1:0]  sw_cnt;
    logic           fast;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    bit  drv_below [0:LAST];
    bit  drv_byp   [0:LAST];

    dldo_ctrl #(
        .N_SW(NSW), .INIT_COUNT(INIT), .SLOW_DIV(SDIV),
        .FAST_DIV(1), .HOLD_SAMPLES(HOLD), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cmp_below_i(below),
        .droop_flag_i(droop), .over_flag_i(over), .bypass_i(bypass),
        .sw_en_o(sw_en), .sw_cnt_o(sw_cnt), .fast_mode_o(fast)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int therm(input int c);
        return (1 << c) - 1;
    endfunction

    // Update edges (counted from reset release) implied by R3, R6, R7:
    // slow every 4th edge; droop set before 65 -> fast after 67, cleared
    // after 74 -> slow after 79; overshoot set before 101 coincides with
    // slow sample 103; cleared after 110 -> slow after 115; droop before 141
    // coincides with slow sample 143.
    function automatic bit is_sample(input int e);
        return (e <= 64 && e % 4 == 0) || (e >= 68 && e <= 79) ||
               (e >= 83 && e <= 103 && (e - 83) % 4 == 0) ||
               (e >= 104 && e <= 115) ||
               (e >= 119 && e <= 143 && (e - 119) % 4 == 0) ||
               (e >= 144 && e <= 145);
    endfunction

    function automatic bit is_fast(input int e);
        return (e >= 67 && e <= 78) || (e >= 103 && e <= 114) ||
               (e >= 143 && e <= 145);
    endfunction

    initial begin
        int exp_cnt;
        string tag;
        exp_cnt = INIT;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 count", int'(sw_cnt), INIT);
        check("R1 gates", int'(sw_en), therm(INIT));
        check("R1 rate", int'(fast), 0);
        rst_n = 1'b1;
        for (int e = 1; e <= LAST; e++) begin
            if (e == 27)  below = 1'b0;
            if (e == 47)  below = 1'b1;
            if (e == 65)  begin droop = 1'b1; below = 1'b1; end
            if (e == 75)  droop = 1'b0;
            if (e == 101) begin over = 1'b1; below = 1'b0; end
            if (e == 111) over = 1'b0;
            if (e == 120) below = 1'b1;
            if (e == 122) bypass = 1'b1;
            if (e == 131) bypass = 1'b0;
            if (e == 141) droop = 1'b1;
            if (e == 146) begin rst_n = 1'b0; droop = 1'b0; end
            if (e == 148) rst_n = 1'b1;
            if (e == 122) begin
                #1;
                // R8: bypass acts in the same cycle
                check("R8 gates on entry", int'(sw_en), therm(NSW));
                check("R8 count on entry", int'(sw_cnt), NSW);
            end
            if (e == 131) begin
                #1;
                // R8: stored count reappears, frozen through bypass
                check("R8 count restored", int'(sw_cnt), exp_cnt);
            end
            drv_below[e] = below;
            drv_byp[e]   = bypass;
            @(posedge clk);
            @(negedge clk);
            if (e >= 146) begin
                check("R1 count after reset", int'(sw_cnt), INIT);
                check("R1 gates after reset", int'(sw_en), therm(INIT));
                check("R1 rate after reset", int'(fast), 0);
            end else begin
                if (is_sample(e) && !drv_byp[e]) begin
                    if (drv_below[e-2]) begin
                        if (exp_cnt < NSW) exp_cnt++;
                    end else begin
                        if (exp_cnt > 0) exp_cnt--;
                    end
                end
                if (bypass) begin
                    check("R8 gates held on", int'(sw_en), therm(NSW));
                    check("R8 count reads full", int'(sw_cnt), NSW);
                end else begin
                    if (e == 48)                          tag = "R5 sync delay";
                    else if (exp_cnt == 0 || exp_cnt == NSW) tag = "R4 saturation";
                    else if (is_fast(e - 1))              tag = "R6 fast step";
                    else                                  tag = "R3 slow step";
                    check(tag, int'(sw_cnt), exp_cnt);
                    check("R2 thermometer", int'(sw_en), therm(exp_cnt));
                end
                if ((e >= 75 && e <= 82) || (e >= 111 && e <= 118))
                    tag = "R7 hold and exit";
                else if (e == 67 || e == 103 || e == 143)
                    tag = "R6 fast entry";
                else
                    tag = "R9 rate flag";
                check(tag, int'(fast), int'(is_fast(e)));
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #2000000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule